// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block keeps the replacement state for a small ring of physical page frames. Every frame has an occupancy flag and a single use bit. One hand pointer marks the frame holding the oldest page. The memory manager reports each access to a resident page on the touch port, and that access sets the frame's use bit. When a new page has to be brought in, the manager raises a placement request.

While some frames are still empty, the request is served at once. The first empty frame at or after the hand is chosen, with no search. Once every frame is occupied, the block starts a sweep. On each clock it looks at the frame under the hand. If that frame's use bit is set, the bit is cleared and the hand moves on. The first frame whose bit is already clear becomes the victim. The chosen frame is reported for one cycle, together with a flag that says whether a resident page was evicted. The new page starts with its use bit clear, and the hand moves to the frame after it.

The hand position and the use-bit vector are outputs. The manager can use them to follow the ring, and the bench uses them to observe the state.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0, all frames are empty, every use bit is 0, and busy and place_done are low.
- R2: A touch naming an occupied frame sets that frame's use bit (use_bits bit i belongs to frame i). A touch naming an empty frame leaves use_bits unchanged.
- R3: A request made while at least one frame is empty takes the first empty frame at or after the hand, in ring order 0,1,2,3,0. place_done rises on the clock edge that accepts the request, with place_evict = 0, and busy never rises.
- R4: A page placed into a frame, whether the frame was empty or evicted, leaves that frame's use bit at 0.
- R5: During a sweep, a frame under the hand whose use bit is 1 has that bit cleared and is skipped, and the hand advances by one, wrapping from frame 3 to frame 0.
- R6: The first frame examined with use bit 0 becomes the victim. It is reported with place_done = 1 and place_evict = 1.
- R7: After any placement, hand_pos equals (placed frame + 1) mod 4.
- R8: A sweep examines one frame per clock, starting on the edge after the request is accepted. The result appears on the edge of the final examination. When all four use bits are set, the result appears on the fifth edge after acceptance.
- R9: busy is high from the edge that accepts a request into a sweep until the edge that reports the victim. It falls on that edge.
- R10: A touch that arrives during a sweep is applied before the next examination. A frame whose bit was already cleared by the hand is therefore skipped again when the hand comes round to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | An access to a resident page occurred |
| touch_frame | input | 2 | Frame that was accessed |
| place_req | input | 1 | Request a frame for a new page; sampled only while busy is low |
| busy | output | 1 | Sweep in progress |
| place_done | output | 1 | One-cycle pulse: placement result is valid |
| place_frame | output | 2 | Frame chosen for the new page |
| place_evict | output | 1 | The chosen frame held a page that is now evicted |
| hand_pos | output | 2 | Current hand position |
| use_bits | output | 4 | Use bit of each frame, bit i for frame i |

## Verification
Placement is exercised with five use-bit patterns at the hand:
- Empty frames: separates a direct fill from a sweep.
- Clear bit under the hand: yields a victim after one examination.
- Set bits ahead of a clear one: shows that bits are cleared and skipped.
- All four bits set: gives the full-wrap, worst-case latency.
- All bits set plus a touch during the sweep to an already-cleared frame: shows the touch forces an extra skip and moves the victim one frame further.

In every case the cycle count to place_done, the victim, the hand and the use-bit vector are compared. Together they tell apart an off-by-one in the examination order, a missing clear and a lost touch.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
  typedef enum logic [0:0] {
    SEL_IDLE = 1'b0,
    SEL_SCAN = 1'b1
  } sel_state_e;
endpackage

// File: rtl/frame_flags.sv
module frame_flags #(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_en,
  input  logic [IDX_W-1:0]    touch_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                load_en,
  input  logic [IDX_W-1:0]    load_idx,
  output logic [N_FRAMES-1:0] use_q,
  output logic [N_FRAMES-1:0] occ_q
);

  for (genvar gi = 0; gi < N_FRAMES; gi++) begin : g_frame
    logic touch_hit, clr_hit, load_hit;
    logic use_d, occ_d, upd_en;

    assign touch_hit = touch_en && (touch_idx == IDX_W'(gi)) && occ_q[gi];
    assign clr_hit   = clr_en   && (clr_idx   == IDX_W'(gi));
    assign load_hit  = load_en  && (load_idx  == IDX_W'(gi));
    assign upd_en    = touch_hit || clr_hit || load_hit;

    // Order of precedence: a load beats a touch, and a touch beats a sweep clear.
    always_comb begin
      use_d = use_q[gi];
      occ_d = occ_q[gi];
      if (clr_hit)   use_d = 1'b0;
      if (touch_hit) use_d = 1'b1;
      if (load_hit) begin
        use_d = 1'b0;
        occ_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_q[gi] <= 1'b0;
        occ_q[gi] <= 1'b0;
      end else if (upd_en) begin
        use_q[gi] <= use_d;
        occ_q[gi] <= occ_d;
      end
    end
  end

endmodule

// File: rtl/hand_ring.sv
module hand_ring #(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             jump_en,
  input  logic [IDX_W-1:0] jump_idx,
  output logic [IDX_W-1:0] hand_q
);

  logic [IDX_W-1:0] hand_d;
  logic             hand_en;

  function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(N_FRAMES - 1)) ? '0 : v + 1'b1;
  endfunction

  // A jump lands one frame past the frame just filled.
  always_comb begin
    hand_en = adv_en || jump_en;
    hand_d  = hand_q;
    if (jump_en)     hand_d = ring_inc(jump_idx);
    else if (adv_en) hand_d = ring_inc(hand_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hand_q <= '0;
    else if (hand_en) hand_q <= hand_d;
  end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import clock_victim_pkg::*;
#(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                place_req,
  input  logic [N_FRAMES-1:0] use_q,
  input  logic [N_FRAMES-1:0] occ_q,
  input  logic [IDX_W-1:0]    hand_q,
  output logic                clr_en,
  output logic [IDX_W-1:0]    clr_idx,
  output logic                load_en,
  output logic [IDX_W-1:0]    load_idx,
  output logic                adv_en,
  output logic                jump_en,
  output logic [IDX_W-1:0]    jump_idx,
  output logic                busy,
  output logic                done_q,
  output logic [IDX_W-1:0]    frame_q,
  output logic                evict_q
);

  sel_state_e       state_q, state_d;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             done_d, evict_d;
  logic [IDX_W-1:0] frame_d;

  // First empty frame at or after the hand, in ring order.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int k = 0; k < N_FRAMES; k++) begin
      int pos;
      pos = int'(hand_q) + k;
      if (pos >= N_FRAMES) pos = pos - N_FRAMES;
      if (!free_found && !occ_q[pos]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(pos);
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    clr_en   = 1'b0;
    clr_idx  = hand_q;
    load_en  = 1'b0;
    load_idx = hand_q;
    adv_en   = 1'b0;
    jump_en  = 1'b0;
    jump_idx = free_idx;
    done_d   = 1'b0;
    frame_d  = hand_q;
    evict_d  = 1'b0;
    case (state_q)
      SEL_IDLE: begin
        if (place_req) begin
          if (free_found) begin
            load_en  = 1'b1;
            load_idx = free_idx;
            jump_en  = 1'b1;
            done_d   = 1'b1;
            frame_d  = free_idx;
          end else begin
            state_d = SEL_SCAN;
          end
        end
      end
      SEL_SCAN: begin
        adv_en = 1'b1;
        if (use_q[hand_q]) begin
          clr_en = 1'b1;
        end else begin
          load_en = 1'b1;
          done_d  = 1'b1;
          evict_d = 1'b1;
          state_d = SEL_IDLE;
        end
      end
      default: state_d = SEL_IDLE;
    endcase
  end

  assign busy = (state_q == SEL_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      evict_q <= 1'b0;
    end else if (done_d || done_q) begin
      frame_q <= frame_d;
      evict_q <= evict_d;
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_valid,
  input  logic [IDX_W-1:0]    touch_frame,
  input  logic                place_req,
  output logic                busy,
  output logic                place_done,
  output logic [IDX_W-1:0]    place_frame,
  output logic                place_evict,
  output logic [IDX_W-1:0]    hand_pos,
  output logic [N_FRAMES-1:0] use_bits
);

  logic [N_FRAMES-1:0] use_q, occ_q;
  logic [IDX_W-1:0]    hand_q;
  logic                clr_en, load_en, adv_en, jump_en;
  logic [IDX_W-1:0]    clr_idx, load_idx, jump_idx;
  logic                done_q, evict_q;
  logic [IDX_W-1:0]    frame_q;

  frame_flags #(.N_FRAMES(N_FRAMES)) flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_valid),
    .touch_idx (touch_frame),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .use_q     (use_q),
    .occ_q     (occ_q)
  );

  hand_ring #(.N_FRAMES(N_FRAMES)) hand_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .jump_en  (jump_en),
    .jump_idx (jump_idx),
    .hand_q   (hand_q)
  );

  scan_ctrl #(.N_FRAMES(N_FRAMES)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .place_req (place_req),
    .use_q     (use_q),
    .occ_q     (occ_q),
    .hand_q    (hand_q),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .adv_en    (adv_en),
    .jump_en   (jump_en),
    .jump_idx  (jump_idx),
    .busy      (busy),
    .done_q    (done_q),
    .frame_q   (frame_q),
    .evict_q   (evict_q)
  );

  assign place_done  = done_q;
  assign place_frame = frame_q;
  assign place_evict = evict_q;
  assign hand_pos    = hand_q;
  assign use_bits    = use_q;

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = $clog2(N_FRAMES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                place_done,
  input logic [IDX_W-1:0]    place_frame,
  input logic                place_evict,
  input logic [IDX_W-1:0]    hand_pos,
  input logic [N_FRAMES-1:0] use_bits
);

  function automatic logic [IDX_W-1:0] ring_inc(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(N_FRAMES - 1)) ? '0 : v + 1'b1;
  endfunction

  // R7
  hand_after_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_done |-> hand_pos == ring_inc(place_frame));

  // R4
  placed_use_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_done |-> !use_bits[place_frame]);

  // R6
  evict_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_evict |-> place_done);

  // R3
  fill_no_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (place_done && !place_evict) |-> !$past(busy));

  // R9
  busy_falls_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> place_done);

  // R5
  hand_steps_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> hand_pos == ring_inc($past(hand_pos)));

endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N_FRAMES(N_FRAMES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .place_done  (place_done),
  .place_frame (place_frame),
  .place_evict (place_evict),
  .hand_pos    (hand_pos),
  .use_bits    (use_bits)
);

// File: tb/clock_victim_sel_tb_top.sv
`timescale 1ns/1ps
module clock_victim_sel_tb_top;

  logic       clk;
  logic       rst_n;
  logic       touch_valid;
  logic [1:0] touch_frame;
  logic       place_req;
  logic       busy;
  logic       place_done;
  logic [1:0] place_frame;
  logic       place_evict;
  logic [1:0] hand_pos;
  logic [3:0] use_bits;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  clock_victim_sel dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_valid (touch_valid),
    .touch_frame (touch_frame),
    .place_req   (place_req),
    .busy        (busy),
    .place_done  (place_done),
    .place_frame (place_frame),
    .place_evict (place_evict),
    .hand_pos    (hand_pos),
    .use_bits    (use_bits)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    touch_valid = 1'b1;
    touch_frame = 2'(f);
    @(negedge clk);
    touch_valid = 1'b0;
  endtask

  // Raise a request, return edges until place_done (acceptance edge counts 1)
  // and the busy level seen after the acceptance edge.
  task automatic place(output int cycles, output logic busy1);
    @(negedge clk);
    place_req = 1'b1;
    @(posedge clk); #1;
    place_req = 1'b0;
    busy1  = busy;
    cycles = 1;
    while (!place_done && cycles < 20) begin
      @(posedge clk); #1;
      cycles++;
    end
  endtask

  task automatic t_reset;
    check(hand_pos == 2'd0, "R1 hand", hand_pos, 0);
    check(use_bits == 4'b0000, "R1 use_bits", use_bits, 0);
    check(!busy && !place_done, "R1 busy/done", {busy, place_done}, 0);
  endtask

  task automatic t_touch_empty;
    touch(2);
    #1;
    check(use_bits == 4'b0000, "R2 touch on empty frame ignored", use_bits, 0);
  endtask

  task automatic t_fill_all;
    int c; logic b;
    for (int f = 0; f < 4; f++) begin
      place(c, b);
      check(c == 1 && !b, "R3 fill latency/busy", c, 1);
      check(place_frame == 2'(f) && !place_evict, "R3 fill frame", place_frame, f);
      check(hand_pos == 2'((f + 1) % 4), "R7 hand after fill", hand_pos, (f + 1) % 4);
      check(use_bits == 4'b0000, "R4 filled use bit", use_bits, 0);
    end
  endtask

  task automatic t_touch_set;
    touch(1);
    touch(2);
    #1;
    check(use_bits == 4'b0110, "R2 touch sets use bits", use_bits, 6);
  endtask

  task automatic t_victim_first;
    int c; logic b;
    place(c, b);
    check(b == 1'b1, "R9 busy during sweep", b, 1);
    check(c == 2, "R8 one examination latency", c, 2);
    check(place_frame == 2'd0 && place_evict, "R6 victim frame 0", place_frame, 0);
    check(!busy, "R9 busy falls with done", busy, 0);
    check(hand_pos == 2'd1, "R7 hand after victim", hand_pos, 1);
    check(use_bits == 4'b0110, "R4 victim use bit", use_bits, 6);
  endtask

  task automatic t_skip_set;
    int c; logic b;
    place(c, b);
    check(c == 4, "R8 three examinations", c, 4);
    check(place_frame == 2'd3 && place_evict, "R6 victim after skips", place_frame, 3);
    check(use_bits == 4'b0000, "R5 skipped bits cleared", use_bits, 0);
    check(hand_pos == 2'd0, "R5 hand wraps", hand_pos, 0);
  endtask

  task automatic t_all_set;
    int c; logic b;
    for (int f = 0; f < 4; f++) touch(f);
    #1;
    check(use_bits == 4'b1111, "R2 all bits set", use_bits, 15);
    place(c, b);
    check(c == 6, "R8 full wrap result on fifth edge", c, 6);
    check(place_frame == 2'd0 && place_evict, "R6 full wrap victim", place_frame, 0);
    check(use_bits == 4'b0000 && hand_pos == 2'd1, "R5 full wrap state",
          {hand_pos, use_bits}, {2'd1, 4'b0000});
  endtask

  task automatic t_touch_in_sweep;
    int c;
    for (int f = 0; f < 4; f++) touch(f);
    @(negedge clk);
    place_req = 1'b1;
    @(posedge clk); #1;
    place_req = 1'b0;
    c = 1;
    @(posedge clk); #1;
    c++;
    touch_valid = 1'b1;
    touch_frame = 2'd1;
    @(posedge clk); #1;
    c++;
    touch_valid = 1'b0;
    check(use_bits[1] == 1'b1, "R10 touch applied during sweep", use_bits[1], 1);
    while (!place_done && c < 20) begin
      @(posedge clk); #1;
      c++;
    end
    check(c == 7, "R10 extra skip latency", c, 7);
    check(place_frame == 2'd2 && place_evict, "R10 victim moved on", place_frame, 2);
    check(hand_pos == 2'd3 && use_bits == 4'b0000, "R10 final state",
          {hand_pos, use_bits}, {2'd3, 4'b0000});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    touch_valid = 1'b0;
    touch_frame = 2'd0;
    place_req   = 1'b0;
    rst_n       = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_touch_empty();
    t_fill_all();
    t_touch_set();
    t_victim_first();
    t_skip_set();
    t_all_set();
    t_touch_in_sweep();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    #100000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule